// File: doc/BRIEF.md
# Pipeline State Consistency Monitor

This block observes the pipeline registers of a five-stage processor and reports, in the same cycle, whether the state they hold could occur in normal operation. For the decode stage it looks at the status and instruction code. For the execute, memory and write-back stages it also looks at the two destination register fields. It applies three kinds of rule. The first is a legality rule inside each stage that ties the status to the instruction code and destinations. The second is a spacing rule that requires bubbles behind a return instruction. The third is a rule that at most one destination is written per stage.

Two registered bits track the combined consistency flag and the single-write flag from one cycle to the next. A break flag goes high in any cycle where a check that held in the previous sampled state fails in the current one, which marks a broken invariant. A sticky flag records that any check has failed since reset. The monitor has no effect on the processor. It can sit beside a core in simulation or in silicon as a health indicator.

Top module: `pcm_monitor`

## Requirements
- R1: `pipe_ok` is high exactly when `d_ok`, `e_ok`, `m_ok`, `w_ok` and `ret_ok` are all high.
- R2: In any stage, status OK (code 1) passes only when the instruction code is neither halt (0x0) nor the invalid marker (0xF).
- R3: Status bubble (code 0) passes only with instruction code nop (0x1) and, in execute, memory and write-back, both destinations equal to the none register (0xF).
- R4: Status halt (code 2) passes only with instruction code halt (0x0).
- R5: Status invalid-instruction (code 4) in any stage, and status address-error (code 3) in decode, execute and memory, pass only with nop and no destinations. Address-error status in write-back places no constraint on that stage.
- R6: Status codes 5, 6 and 7 fail the stage's check.
- R7: `ret_ok` is low when a return (0x9) is in execute and decode is not a bubble, or when a return is in memory and decode or execute is not a bubble.
- R8: `ret_ok` is low when a return is in write-back with status OK and any of decode, execute or memory is not a bubble. A return in write-back with any other status imposes nothing.
- R9: `sw_ok` is low exactly when, in at least one of execute, memory and write-back, both destinations differ from 0xF.
- R10: `brk_pipe` (or `brk_sw`) is high when `pipe_ok` (or `sw_ok`) was high at the previous rising clock edge after reset and is low now. The first cycle after reset cannot raise either flag.
- R11: `viol_sticky` rises on the clock edge after any cycle in which `pipe_ok` or `sw_ok` is low. It then stays high until reset. Reset clears it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_stat | input | 3 | Decode status |
| d_icode | input | 4 | Decode instruction code |
| e_stat | input | 3 | Execute status |
| e_icode | input | 4 | Execute instruction code |
| e_dst_e | input | 4 | Execute ALU destination |
| e_dst_m | input | 4 | Execute memory destination |
| m_stat | input | 3 | Memory status |
| m_icode | input | 4 | Memory instruction code |
| m_dst_e | input | 4 | Memory ALU destination |
| m_dst_m | input | 4 | Memory memory destination |
| w_stat | input | 3 | Write-back status |
| w_icode | input | 4 | Write-back instruction code |
| w_dst_e | input | 4 | Write-back ALU destination |
| w_dst_m | input | 4 | Write-back memory destination |
| d_ok | output | 1 | Decode stage rule holds |
| e_ok | output | 1 | Execute stage rule holds |
| m_ok | output | 1 | Memory stage rule holds |
| w_ok | output | 1 | Write-back stage rule holds |
| ret_ok | output | 1 | Return spacing rule holds |
| pipe_ok | output | 1 | Combined consistency flag |
| sw_ok | output | 1 | Single-write flag |
| brk_pipe | output | 1 | Combined flag held before, fails now |
| brk_sw | output | 1 | Single-write flag held before, fails now |
| viol_sticky | output | 1 | A check has failed since reset |

## Verification
The assertions assume that all pipeline inputs carry known values at every rising edge while reset is released. They also assume that reset is asserted before the first edge, so that the previous-state bits start from a defined value. The bench changes inputs only on falling edges and drives every input before reset is released. All 3-bit and 4-bit values the inputs can take are used, including the unused status codes. About half of the cycles hold a fully legal state, so that both break flags see passing states followed by failing ones.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int STAT_W  = 3;
  localparam int ICODE_W = 4;
  localparam int REG_W   = 4;
  localparam int N_DST_STAGES = 3;
  localparam int N_TRACK = 2;

  localparam logic [STAT_W-1:0] ST_BUB = 3'd0;
  localparam logic [STAT_W-1:0] ST_AOK = 3'd1;
  localparam logic [STAT_W-1:0] ST_HLT = 3'd2;
  localparam logic [STAT_W-1:0] ST_ADR = 3'd3;
  localparam logic [STAT_W-1:0] ST_INS = 3'd4;

  localparam logic [ICODE_W-1:0] IC_HALT = 4'h0;
  localparam logic [ICODE_W-1:0] IC_NOP  = 4'h1;
  localparam logic [ICODE_W-1:0] IC_RET  = 4'h9;
  localparam logic [ICODE_W-1:0] IC_BAD  = 4'hF;

  localparam logic [REG_W-1:0] REG_NONE = 4'hF;

  typedef struct packed {
    logic [STAT_W-1:0]  stat;
    logic [ICODE_W-1:0] icode;
    logic [REG_W-1:0]   dst_e;
    logic [REG_W-1:0]   dst_m;
  } stage_t;
endpackage

// File: rtl/pcm_stage_rule.sv
module pcm_stage_rule
  import pcm_pkg::*;
#(
  parameter bit CHK_ADR = 1'b1
) (
  input  stage_t stg_i,
  output logic   ok_o
);
  logic dst_none;
  logic empty_slot;
  logic adr_ok;

  assign dst_none   = (stg_i.dst_e == REG_NONE) && (stg_i.dst_m == REG_NONE);
  assign empty_slot = dst_none && (stg_i.icode == IC_NOP);

  generate
    if (CHK_ADR) begin : g_adr_strict
      assign adr_ok = empty_slot;
    end else begin : g_adr_free
      assign adr_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (stg_i.stat)
      ST_AOK:  ok_o = (stg_i.icode != IC_HALT) && (stg_i.icode != IC_BAD);
      ST_BUB:  ok_o = empty_slot;
      ST_HLT:  ok_o = (stg_i.icode == IC_HALT);
      ST_INS:  ok_o = empty_slot;
      ST_ADR:  ok_o = adr_ok;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcm_ret_rule.sv
module pcm_ret_rule
  import pcm_pkg::*;
(
  input  logic [STAT_W-1:0]  d_stat,
  input  logic [STAT_W-1:0]  e_stat,
  input  logic [ICODE_W-1:0] e_icode,
  input  logic [STAT_W-1:0]  m_stat,
  input  logic [ICODE_W-1:0] m_icode,
  input  logic [STAT_W-1:0]  w_stat,
  input  logic [ICODE_W-1:0] w_icode,
  output logic               ok_o
);
  logic d_bub, e_bub, m_bub;
  logic ret_e_bad, ret_m_bad, ret_w_bad;

  always_comb begin
    d_bub = (d_stat == ST_BUB);
    e_bub = (e_stat == ST_BUB);
    m_bub = (m_stat == ST_BUB);
    ret_e_bad = (e_icode == IC_RET) && !d_bub;
    ret_m_bad = (m_icode == IC_RET) && !(d_bub && e_bub);
    ret_w_bad = (w_icode == IC_RET) && (w_stat == ST_AOK) && !(d_bub && e_bub && m_bub);
    ok_o = !(ret_e_bad || ret_m_bad || ret_w_bad);
  end
endmodule

// File: rtl/pcm_track.sv
module pcm_track #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pass_i,
  output logic [N-1:0] brk_o,
  output logic         sticky_o
);
  logic [N-1:0] prev_q, prev_d;
  logic         sticky_q, sticky_d;
  logic         track_en;

  always_comb begin
    track_en = 1'b1;
    prev_d   = pass_i;
    sticky_d = sticky_q | ~(&pass_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= 1'b0;
    end else if (track_en) begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign brk_o    = prev_q & ~pass_i;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/pcm_monitor.sv
module pcm_monitor
  import pcm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAT_W-1:0]  d_stat,
  input  logic [ICODE_W-1:0] d_icode,
  input  logic [STAT_W-1:0]  e_stat,
  input  logic [ICODE_W-1:0] e_icode,
  input  logic [REG_W-1:0]   e_dst_e,
  input  logic [REG_W-1:0]   e_dst_m,
  input  logic [STAT_W-1:0]  m_stat,
  input  logic [ICODE_W-1:0] m_icode,
  input  logic [REG_W-1:0]   m_dst_e,
  input  logic [REG_W-1:0]   m_dst_m,
  input  logic [STAT_W-1:0]  w_stat,
  input  logic [ICODE_W-1:0] w_icode,
  input  logic [REG_W-1:0]   w_dst_e,
  input  logic [REG_W-1:0]   w_dst_m,
  output logic               d_ok,
  output logic               e_ok,
  output logic               m_ok,
  output logic               w_ok,
  output logic               ret_ok,
  output logic               pipe_ok,
  output logic               sw_ok,
  output logic               brk_pipe,
  output logic               brk_sw,
  output logic               viol_sticky
);
  localparam int N_STAGES = N_DST_STAGES + 1;

  stage_t                 stg [N_STAGES];
  logic [N_STAGES-1:0]    stage_ok;
  logic [N_DST_STAGES-1:0] one_dst;
  logic [N_TRACK-1:0]     pass_vec;
  logic [N_TRACK-1:0]     brk_vec;

  // decode carries no destinations: tie them to the none register
  assign stg[0] = '{stat: d_stat, icode: d_icode, dst_e: REG_NONE, dst_m: REG_NONE};
  assign stg[1] = '{stat: e_stat, icode: e_icode, dst_e: e_dst_e, dst_m: e_dst_m};
  assign stg[2] = '{stat: m_stat, icode: m_icode, dst_e: m_dst_e, dst_m: m_dst_m};
  assign stg[3] = '{stat: w_stat, icode: w_icode, dst_e: w_dst_e, dst_m: w_dst_m};

  generate
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      pcm_stage_rule #(.CHK_ADR(s != N_STAGES - 1)) u_rule (
        .stg_i (stg[s]),
        .ok_o  (stage_ok[s])
      );
    end
    for (genvar k = 0; k < N_DST_STAGES; k++) begin : g_sw
      assign one_dst[k] = (stg[k+1].dst_e == REG_NONE) || (stg[k+1].dst_m == REG_NONE);
    end
  endgenerate

  pcm_ret_rule u_ret (
    .d_stat  (d_stat),
    .e_stat  (e_stat),
    .e_icode (e_icode),
    .m_stat  (m_stat),
    .m_icode (m_icode),
    .w_stat  (w_stat),
    .w_icode (w_icode),
    .ok_o    (ret_ok)
  );

  assign d_ok    = stage_ok[0];
  assign e_ok    = stage_ok[1];
  assign m_ok    = stage_ok[2];
  assign w_ok    = stage_ok[3];
  assign pipe_ok = (&stage_ok) && ret_ok;
  assign sw_ok   = &one_dst;

  assign pass_vec = {sw_ok, pipe_ok};

  pcm_track #(.N(N_TRACK)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .pass_i   (pass_vec),
    .brk_o    (brk_vec),
    .sticky_o (viol_sticky)
  );

  assign brk_pipe = brk_vec[0];
  assign brk_sw   = brk_vec[1];
endmodule

// File: rtl/pcm_monitor_sva.sv
module pcm_monitor_sva
  import pcm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [STAT_W-1:0]  d_stat,
  input logic [ICODE_W-1:0] e_icode,
  input logic [REG_W-1:0]   e_dst_e,
  input logic [REG_W-1:0]   e_dst_m,
  input logic [STAT_W-1:0]  m_stat,
  input logic [ICODE_W-1:0] m_icode,
  input logic [STAT_W-1:0]  w_stat,
  input logic [ICODE_W-1:0] w_icode,
  input logic               m_ok,
  input logic               w_ok,
  input logic               pipe_ok,
  input logic               sw_ok,
  input logic               brk_pipe,
  input logic               brk_sw,
  input logic               viol_sticky
);
  p_bubble_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stat == ST_BUB && m_icode != IC_NOP) |-> !m_ok);

  p_halt_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat == ST_HLT && w_icode != IC_HALT) |-> !w_ok);

  p_ret_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (e_icode == IC_RET && d_stat != ST_BUB) |-> !pipe_ok);

  p_double_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst_e != REG_NONE && e_dst_m != REG_NONE) |-> !sw_ok);

  p_break_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pipe |-> (!pipe_ok && $past(pipe_ok)));

  p_break_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_sw |-> (!sw_ok && $past(sw_ok)));

  p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_ok || !sw_ok) |=> viol_sticky);

  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_sticky |=> viol_sticky);
endmodule

bind pcm_monitor pcm_monitor_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .d_stat      (d_stat),
  .e_icode     (e_icode),
  .e_dst_e     (e_dst_e),
  .e_dst_m     (e_dst_m),
  .m_stat      (m_stat),
  .m_icode     (m_icode),
  .w_stat      (w_stat),
  .w_icode     (w_icode),
  .m_ok        (m_ok),
  .w_ok        (w_ok),
  .pipe_ok     (pipe_ok),
  .sw_ok       (sw_ok),
  .brk_pipe    (brk_pipe),
  .brk_sw      (brk_sw),
  .viol_sticky (viol_sticky)
);

// File: tb/pcm_monitor_test.sv
module pcm_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] d_stat, e_stat, m_stat, w_stat;
  logic [3:0] d_icode, e_icode, m_icode, w_icode;
  logic [3:0] e_dst_e, e_dst_m, m_dst_e, m_dst_m, w_dst_e, w_dst_m;
  logic d_ok, e_ok, m_ok, w_ok, ret_ok, pipe_ok, sw_ok, brk_pipe, brk_sw, viol_sticky;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state, updated at each rising edge outside reset
  bit ref_prev_pipe = 1'b0;
  bit ref_prev_sw = 1'b0;
  bit ref_sticky = 1'b0;

  always #10 clk = ~clk;

  pcm_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .d_stat(d_stat), .d_icode(d_icode),
    .e_stat(e_stat), .e_icode(e_icode), .e_dst_e(e_dst_e), .e_dst_m(e_dst_m),
    .m_stat(m_stat), .m_icode(m_icode), .m_dst_e(m_dst_e), .m_dst_m(m_dst_m),
    .w_stat(w_stat), .w_icode(w_icode), .w_dst_e(w_dst_e), .w_dst_m(w_dst_m),
    .d_ok(d_ok), .e_ok(e_ok), .m_ok(m_ok), .w_ok(w_ok), .ret_ok(ret_ok),
    .pipe_ok(pipe_ok), .sw_ok(sw_ok), .brk_pipe(brk_pipe), .brk_sw(brk_sw),
    .viol_sticky(viol_sticky)
  );

  function automatic bit want_stage(int st, int ic, int de, int dm, bit adr_rule);
    bit clean = (ic == 1) && (de == 15) && (dm == 15);
    if (st == 1) return (ic != 0) && (ic != 15);
    if (st == 0 || st == 4) return clean;
    if (st == 2) return ic == 0;
    if (st == 3) return adr_rule ? clean : 1'b1;
    return 1'b0;
  endfunction

  function automatic bit want_ret();
    bit r = 1'b1;
    if (e_icode == 9 && d_stat != 0) r = 1'b0;
    if (m_icode == 9 && (d_stat != 0 || e_stat != 0)) r = 1'b0;
    if (w_icode == 9 && w_stat == 1 && (d_stat != 0 || e_stat != 0 || m_stat != 0)) r = 1'b0;
    return r;
  endfunction

  task automatic check(string tag, logic act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic all_bubble();
    d_stat = 0; d_icode = 1;
    e_stat = 0; e_icode = 1; e_dst_e = 15; e_dst_m = 15;
    m_stat = 0; m_icode = 1; m_dst_e = 15; m_dst_m = 15;
    w_stat = 0; w_icode = 1; w_dst_e = 15; w_dst_m = 15;
  endtask

  // compare all outputs against the reference, then advance the reference
  task automatic compare();
    bit xd, xe, xm, xw, xr, xp, xs;
    #2;
    xd = want_stage(d_stat, d_icode, 15, 15, 1'b1);
    xe = want_stage(e_stat, e_icode, e_dst_e, e_dst_m, 1'b1);
    xm = want_stage(m_stat, m_icode, m_dst_e, m_dst_m, 1'b1);
    xw = want_stage(w_stat, w_icode, w_dst_e, w_dst_m, 1'b0);
    xr = want_ret();
    xp = xd && xe && xm && xw && xr;
    xs = (e_dst_e == 15 || e_dst_m == 15) && (m_dst_e == 15 || m_dst_m == 15)
         && (w_dst_e == 15 || w_dst_m == 15);
    check("R2/R3/R4/R5/R6 d_ok", d_ok, xd);
    check("R2/R3/R4/R5/R6 e_ok", e_ok, xe);
    check("R2/R3/R4/R5/R6 m_ok", m_ok, xm);
    check("R2/R3/R4/R5/R6 w_ok", w_ok, xw);
    check("R7/R8 ret_ok", ret_ok, xr);
    check("R1 pipe_ok", pipe_ok, xp);
    check("R9 sw_ok", sw_ok, xs);
    check("R10 brk_pipe", brk_pipe, ref_prev_pipe && !xp);
    check("R10 brk_sw", brk_sw, ref_prev_sw && !xs);
    check("R11 viol_sticky", viol_sticky, ref_sticky);
    ref_prev_pipe = xp;
    ref_prev_sw = xs;
    ref_sticky = ref_sticky || !xp || !xs;
  endtask

  task automatic step();
    compare();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R11 reset clears viol_sticky", viol_sticky, 1'b0);
    check("R10 reset clears brk_pipe", brk_pipe, 1'b0);
    check("R10 reset clears brk_sw", brk_sw, 1'b0);
    ref_prev_pipe = 1'b0;
    ref_prev_sw = 1'b0;
    ref_sticky = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [3:0] pick_reg();
    int r = $urandom_range(0, 3);
    return (r < 2) ? 4'hF : 4'($urandom_range(0, 15));
  endfunction

  function automatic logic [3:0] pick_ic();
    int r = $urandom_range(0, 5);
    case (r)
      0: return 4'h0;
      1: return 4'h1;
      2: return 4'h9;
      3: return 4'hF;
      default: return 4'($urandom_range(0, 15));
    endcase
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    all_bubble();
    @(negedge clk);
    do_reset();

    // R1: legal all-bubble pipe passes everything
    all_bubble(); step();
    // R2: OK status with halt in memory fails
    all_bubble(); m_stat = 1; m_icode = 0; step();
    all_bubble(); e_stat = 1; e_icode = 6; e_dst_e = 3; step();
    all_bubble(); d_stat = 1; d_icode = 15; step();
    // R3: bubble with a live destination fails
    all_bubble(); e_dst_e = 3; step();
    all_bubble(); w_icode = 6; step();
    // R4: halt status needs halt code
    all_bubble(); w_stat = 2; w_icode = 2; step();
    all_bubble(); w_stat = 2; w_icode = 0; step();
    // R5: invalid-instruction and address-error rules, write-back address error free
    all_bubble(); m_stat = 4; step();
    all_bubble(); w_stat = 3; w_icode = 5; w_dst_e = 2; step();
    all_bubble(); e_stat = 3; e_icode = 6; step();
    all_bubble(); w_stat = 4; w_dst_m = 1; step();
    // R6: unused status codes fail
    all_bubble(); d_stat = 6; step();
    all_bubble(); m_stat = 7; step();
    all_bubble(); e_stat = 5; step();
    // R7: return spacing in execute and memory
    all_bubble(); e_stat = 1; e_icode = 9; d_stat = 1; d_icode = 2; step();
    all_bubble(); e_stat = 1; e_icode = 9; step();
    all_bubble(); m_stat = 1; m_icode = 9; e_stat = 1; e_icode = 2; step();
    // R8: return in write-back, with OK and with other statuses
    all_bubble(); w_stat = 1; w_icode = 9; m_stat = 1; m_icode = 3; step();
    all_bubble(); w_stat = 1; w_icode = 9; step();
    all_bubble(); w_stat = 3; w_icode = 9; m_stat = 1; m_icode = 3; step();
    // R9: double destinations
    all_bubble(); e_stat = 1; e_icode = 6; e_dst_e = 2; e_dst_m = 3; step();
    all_bubble(); w_stat = 1; w_icode = 5; w_dst_e = 4; step();
    // R10 and R11: pass then fail, then reset clears state
    all_bubble(); step();
    all_bubble(); m_dst_m = 1; m_dst_e = 2; m_stat = 1; m_icode = 5; step();
    do_reset();
    all_bubble(); d_stat = 7; step();
    all_bubble(); step();

    for (int i = 0; i < 4000; i++) begin
      all_bubble();
      if ($urandom_range(0, 1) == 1) begin
        d_stat = 3'($urandom_range(0, 7)); d_icode = pick_ic();
        e_stat = 3'($urandom_range(0, 7)); e_icode = pick_ic();
        e_dst_e = pick_reg(); e_dst_m = pick_reg();
        m_stat = 3'($urandom_range(0, 7)); m_icode = pick_ic();
        m_dst_e = pick_reg(); m_dst_m = pick_reg();
        w_stat = 3'($urandom_range(0, 7)); w_icode = pick_ic();
        w_dst_e = pick_reg(); w_dst_m = pick_reg();
      end
      if (i % 997 == 500) do_reset();
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule